// File: doc/BRIEF.md
# Sliding Fill Mask Register Bank

This block holds the bit masks for a 64-bit content-addressable word. It has three 64-bit registers. The first is a sliding mask. It moves one position per shift command. Instead of wrapping around, it copies a boundary bit inward, so a run of ones or zeros can grow across the searchable field. The other two form a foreground/background pair. One copy of the pair is active and the other is on standby. A swap command exchanges their roles in a single clock.

The searchable (CAM) part of the word is set at runtime by a 3-bit partition code. The sliding shift acts only inside that field. Bits that belong to the associated-data (RAM) part never move during a shift.

Every register can be loaded one 16-bit segment at a time. A per-bit protect mask keeps chosen bits of the segment unchanged. How the masks are later used by compares or moves lies outside this block.

Top module: `sliding_mask_top`

## Requirements
- R1: After reset, all three masks are zero and the foreground copy is active (`bgActive` = 0).
- R2: The partition code `partCode` sets the CAM field [lo, hi], with k = `partCode[1:0]`. When `partCode[2]`=0, the field is lo = 16k, hi = 63. When `partCode[2]`=1, the field is lo = 0, hi = 63-16k. Codes 000 and 100 both give the full word.
- R3: Shift right (`shiftRight`=1, `shiftLeft`=0) sets bit i to the old bit i+1 for lo ≤ i < hi. Bit hi keeps its value, so it is replicated downward with no wrap.
- R4: Shift left (`shiftLeft`=1, `shiftRight`=0) sets bit i to the old bit i-1 for lo < i ≤ hi. Bit lo keeps its value.
- R5: Bits of the sliding mask outside [lo, hi] never change on a shift.
- R6: A cycle with both `shiftRight` and `shiftLeft` high leaves the sliding mask unchanged.
- R7: A segment write (`wrEn`=1) addresses a register through `wrTarget`: 00 is the sliding mask, 01 the active pair copy, 10 the standby pair copy, and 11 none. Segment s covers bits 16s+15 down to 16s. Each bit takes `wrData`, except where `wrKeep` is 1; there the old bit stays.
- R8: A write to the sliding mask in the same cycle as a shift takes precedence, and the shift is dropped for that cycle.
- R9: `swapPair` exchanges the active and standby roles in one clock and toggles `bgActive`. A write in the same cycle addresses the copies by their roles before the swap.
- R10: `activeMask` shows the background copy when `bgActive`=1 and the foreground copy otherwise. `standbyMask` shows the other copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| partCode | input | 3 | CAM/RAM partition code |
| shiftRight | input | 1 | Slide the sliding mask one bit toward bit 0 |
| shiftLeft | input | 1 | Slide the sliding mask one bit toward bit 63 |
| wrEn | input | 1 | Segment write strobe |
| wrTarget | input | 2 | Register addressed by the write |
| wrSeg | input | 2 | Segment index |
| wrData | input | 16 | Segment write data |
| wrKeep | input | 16 | Per-bit protect, 1 keeps the old bit |
| swapPair | input | 1 | Exchange active and standby pair copies |
| slideMask | output | 64 | Sliding mask contents |
| activeMask | output | 64 | Active copy of the pair |
| standbyMask | output | 64 | Standby copy of the pair |
| bgActive | output | 1 | 1 when the background copy is active |

## Verification
Random shifts are run with all eight partition codes over random mask contents. A fault that puts a limit on the wrong segment edge, or that rotates instead of replicating, then shows up as a wrong bit at the field boundary. Random protect masks and all four write targets separate a merge done on the wrong segment or with the wrong protect polarity. Swaps issued together with writes to the pair show whether role decoding uses the state before the swap. Directed cases cover the two ends of the field: a single one at the top bit under shift right, a single one at the bottom bit under shift left, and the double shift request.

// File: rtl/sliding_mask_pkg.sv
package sliding_mask_pkg;
  localparam int WORD_W    = 64;
  localparam int SEG_W     = 16;
  localparam int SEG_N     = WORD_W / SEG_W;
  localparam int SEG_IDX_W = $clog2(SEG_N);
  localparam int POS_W     = $clog2(WORD_W);
  localparam int CODE_W    = 3;

  typedef enum logic [1:0] {
    TGT_SLIDE   = 2'b00,
    TGT_ACTIVE  = 2'b01,
    TGT_STANDBY = 2'b10,
    TGT_NONE    = 2'b11
  } maskTarget_e;

  typedef struct packed {
    logic                 shR;
    logic                 shL;
    logic                 wrSlide;
    logic                 wrFg;
    logic                 wrBg;
    logic                 swap;
    logic [SEG_IDX_W-1:0] seg;
    logic [SEG_W-1:0]     data;
    logic [SEG_W-1:0]     keep;
    logic [POS_W-1:0]     lo;
    logic [POS_W-1:0]     hi;
  } maskStrobes_t;
endpackage

// File: rtl/sliding_mask_ctrl.sv
module sliding_mask_ctrl
  import sliding_mask_pkg::*;
(
  input  logic [CODE_W-1:0]    partCode,
  input  logic                 shiftRight,
  input  logic                 shiftLeft,
  input  logic                 wrEn,
  input  logic [1:0]           wrTarget,
  input  logic [SEG_IDX_W-1:0] wrSeg,
  input  logic [SEG_W-1:0]     wrData,
  input  logic [SEG_W-1:0]     wrKeep,
  input  logic                 swapPair,
  input  logic                 bgSel,
  output maskStrobes_t         strobes
);
  localparam int RAMSEG_W = CODE_W - 1;

  maskTarget_e         tgt;
  logic [RAMSEG_W-1:0] ramSegs;
  logic [POS_W-1:0]    ramBits;

  assign tgt     = maskTarget_e'(wrTarget);
  assign ramSegs = partCode[RAMSEG_W-1:0];
  assign ramBits = POS_W'(ramSegs) * POS_W'(SEG_W);

  always_comb begin
    strobes         = '0;
    strobes.seg     = wrSeg;
    strobes.data    = wrData;
    strobes.keep    = wrKeep;
    strobes.swap    = swapPair;
    strobes.wrSlide = wrEn && (tgt == TGT_SLIDE);
    strobes.wrFg    = wrEn && ((tgt == TGT_ACTIVE && !bgSel) || (tgt == TGT_STANDBY && bgSel));
    strobes.wrBg    = wrEn && ((tgt == TGT_ACTIVE && bgSel) || (tgt == TGT_STANDBY && !bgSel));
    // A conflicting shift request, or a write to the sliding mask, cancels the shift.
    strobes.shR     = shiftRight && !shiftLeft && !strobes.wrSlide;
    strobes.shL     = shiftLeft && !shiftRight && !strobes.wrSlide;
    if (partCode[CODE_W-1]) begin
      strobes.lo = '0;
      strobes.hi = POS_W'(WORD_W - 1) - ramBits;
    end else begin
      strobes.lo = ramBits;
      strobes.hi = POS_W'(WORD_W - 1);
    end
  end
endmodule

// File: rtl/sliding_mask_dp.sv
module sliding_mask_dp
  import sliding_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  maskStrobes_t      strobes,
  output logic [WORD_W-1:0] slideMask,
  output logic [WORD_W-1:0] fgMask,
  output logic [WORD_W-1:0] bgMask,
  output logic              bgSel
);
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] slideNext;
  logic [WORD_W-1:0] fgNext;
  logic [WORD_W-1:0] bgNext;

  function automatic logic [WORD_W-1:0] mergeSeg(
    input logic [WORD_W-1:0]    old,
    input logic [SEG_IDX_W-1:0] seg,
    input logic [SEG_W-1:0]     data,
    input logic [SEG_W-1:0]     keep
  );
    logic [WORD_W-1:0] res;
    res = old;
    for (int s = 0; s < SEG_N; s++) begin
      if (seg == SEG_IDX_W'(s))
        res[s*SEG_W +: SEG_W] = (old[s*SEG_W +: SEG_W] & keep) | (data & ~keep);
    end
    return res;
  endfunction

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    localparam int UP = (i == WORD_W - 1) ? i : i + 1;
    localparam int DN = (i == 0) ? i : i - 1;
    always_comb begin
      shifted[i] = slideMask[i];
      if (strobes.shR && POS_W'(i) >= strobes.lo && POS_W'(i) < strobes.hi)
        shifted[i] = slideMask[UP];
      else if (strobes.shL && POS_W'(i) > strobes.lo && POS_W'(i) <= strobes.hi)
        shifted[i] = slideMask[DN];
    end
  end

  always_comb begin
    slideNext = strobes.wrSlide ? mergeSeg(slideMask, strobes.seg, strobes.data, strobes.keep)
                                : shifted;
    fgNext    = strobes.wrFg ? mergeSeg(fgMask, strobes.seg, strobes.data, strobes.keep) : fgMask;
    bgNext    = strobes.wrBg ? mergeSeg(bgMask, strobes.seg, strobes.data, strobes.keep) : bgMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slideMask <= '0;
      fgMask    <= '0;
      bgMask    <= '0;
      bgSel     <= 1'b0;
    end else begin
      slideMask <= slideNext;
      fgMask    <= fgNext;
      bgMask    <= bgNext;
      if (strobes.swap) bgSel <= !bgSel;
    end
  end
endmodule

// File: rtl/sliding_mask_top.sv
module sliding_mask_top
  import sliding_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        partCode,
  input  logic              shiftRight,
  input  logic              shiftLeft,
  input  logic              wrEn,
  input  logic [1:0]        wrTarget,
  input  logic [1:0]        wrSeg,
  input  logic [15:0]       wrData,
  input  logic [15:0]       wrKeep,
  input  logic              swapPair,
  output logic [63:0]       slideMask,
  output logic [63:0]       activeMask,
  output logic [63:0]       standbyMask,
  output logic              bgActive
);
  maskStrobes_t      strobes;
  logic [WORD_W-1:0] fgMask;
  logic [WORD_W-1:0] bgMask;
  logic              bgSel;

  sliding_mask_ctrl i_ctrl (
    .partCode  (partCode),
    .shiftRight(shiftRight),
    .shiftLeft (shiftLeft),
    .wrEn      (wrEn),
    .wrTarget  (wrTarget),
    .wrSeg     (wrSeg),
    .wrData    (wrData),
    .wrKeep    (wrKeep),
    .swapPair  (swapPair),
    .bgSel     (bgSel),
    .strobes   (strobes)
  );

  sliding_mask_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .slideMask(slideMask),
    .fgMask   (fgMask),
    .bgMask   (bgMask),
    .bgSel    (bgSel)
  );

  assign activeMask  = bgSel ? bgMask : fgMask;
  assign standbyMask = bgSel ? fgMask : bgMask;
  assign bgActive    = bgSel;
endmodule

// File: rtl/sliding_mask_chk.sv
module sliding_mask_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  partCode,
  input logic        shiftRight,
  input logic        shiftLeft,
  input logic        wrEn,
  input logic [1:0]  wrTarget,
  input logic [1:0]  wrSeg,
  input logic [15:0] wrData,
  input logic [15:0] wrKeep,
  input logic        swapPair,
  input logic [63:0] slideMask,
  input logic [63:0] activeMask,
  input logic [63:0] standbyMask,
  input logic        bgActive
);
  p_both_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (shiftRight && shiftLeft && !wrEn) |=> $stable(slideMask));

  p_top_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (shiftRight && !shiftLeft && !wrEn && !partCode[2]) |=> slideMask[63] == $past(slideMask[63]));

  p_bottom_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (shiftLeft && !shiftRight && !wrEn && partCode[2]) |=> slideMask[0] == $past(slideMask[0]));

  p_ram_side_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && partCode == 3'b011) |=> slideMask[47:0] == $past(slideMask[47:0]));

  p_swap_roles_r9: assert property (@(posedge clk) disable iff (!rstN)
    (swapPair && !wrEn) |=> (activeMask == $past(standbyMask)) && (bgActive != $past(bgActive)));

  p_pair_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!swapPair && !wrEn) |=> $stable(activeMask) && $stable(standbyMask) && $stable(bgActive));

  p_plain_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrTarget == 2'b00 && wrSeg == 2'b00 && wrKeep == 16'h0) |=> slideMask[15:0] == $past(wrData));
endmodule

bind sliding_mask_top sliding_mask_chk i_chk (
  .clk(clk), .rstN(rstN), .partCode(partCode), .shiftRight(shiftRight),
  .shiftLeft(shiftLeft), .wrEn(wrEn), .wrTarget(wrTarget), .wrSeg(wrSeg),
  .wrData(wrData), .wrKeep(wrKeep), .swapPair(swapPair), .slideMask(slideMask),
  .activeMask(activeMask), .standbyMask(standbyMask), .bgActive(bgActive)
);

// File: tb/test_sliding_mask_top.sv
module test_sliding_mask_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  partCode = '0;
  logic        shiftRight = 1'b0, shiftLeft = 1'b0, wrEn = 1'b0, swapPair = 1'b0;
  logic [1:0]  wrTarget = '0, wrSeg = '0;
  logic [15:0] wrData = '0, wrKeep = '0;
  logic [63:0] slideMask, activeMask, standbyMask;
  logic        bgActive;

  logic [63:0] mSlide = '0, mFg = '0, mBg = '0;
  logic        mBgSel = 1'b0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  sliding_mask_top i_sliding_mask_top (.*);

  function automatic int loOf(logic [2:0] c);
    return c[2] ? 0 : 16 * int'(c[1:0]);
  endfunction
  function automatic int hiOf(logic [2:0] c);
    return c[2] ? 63 - 16 * int'(c[1:0]) : 63;
  endfunction

  function automatic logic [63:0] shiftModel(logic [63:0] v, logic [2:0] c, bit right);
    logic [63:0] r = v;
    int lo = loOf(c), hi = hiOf(c);
    for (int i = 0; i < 64; i++) begin
      if (right && i >= lo && i < hi) r[i] = v[i+1];
      if (!right && i > lo && i <= hi) r[i] = v[i-1];
    end
    return r;
  endfunction

  function automatic logic [63:0] writeModel(logic [63:0] v, logic [1:0] s, logic [15:0] d, logic [15:0] k);
    logic [63:0] r = v;
    for (int b = 0; b < 16; b++)
      if (!k[b]) r[16*int'(s) + b] = d[b];
    return r;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check(tag, "slideMask", slideMask, mSlide);
    check("R10", "activeMask", activeMask, mBgSel ? mBg : mFg);
    check("R10", "standbyMask", standbyMask, mBgSel ? mFg : mBg);
    check(tag, "bgActive", 64'(bgActive), 64'(mBgSel));
  endtask

  // Applies inputs at a falling edge and advances the model to the next rising edge.
  task automatic step(logic [2:0] pc, bit sr, bit sl, bit we, logic [1:0] tg,
                      logic [1:0] sg, logic [15:0] d, logic [15:0] k, bit sw);
    partCode = pc; shiftRight = sr; shiftLeft = sl; wrEn = we; wrTarget = tg;
    wrSeg = sg; wrData = d; wrKeep = k; swapPair = sw;
    if (we && tg == 2'b00) mSlide = writeModel(mSlide, sg, d, k);
    else if (sr && !sl) mSlide = shiftModel(mSlide, pc, 1);
    else if (sl && !sr) mSlide = shiftModel(mSlide, pc, 0);
    if (we && ((tg == 2'b01 && !mBgSel) || (tg == 2'b10 && mBgSel))) mFg = writeModel(mFg, sg, d, k);
    if (we && ((tg == 2'b01 && mBgSel) || (tg == 2'b10 && !mBgSel))) mBg = writeModel(mBg, sg, d, k);
    if (sw) mBgSel = !mBgSel;
    @(negedge clk);
  endtask

  task automatic loadSlide(logic [63:0] v);
    for (int s = 0; s < 4; s++) step(3'b000, 0, 0, 1, 2'b00, 2'(s), v[16*s +: 16], 16'h0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10ns);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R3: a single one at the field top replicates downward, no wrap to bit 0.
    loadSlide(64'h8000_0000_0000_0000);
    step(3'b000, 1, 0, 0, 0, 0, 0, 0, 0); checkAll("R3");
    step(3'b000, 1, 0, 0, 0, 0, 0, 0, 0); checkAll("R3");
    check("R3", "top pair", slideMask, 64'hE000_0000_0000_0000);
    // R4: a single one at the field bottom replicates upward.
    loadSlide(64'h0000_0000_0000_0001);
    step(3'b000, 0, 1, 0, 0, 0, 0, 0, 0); checkAll("R4");
    check("R4", "bottom pair", slideMask, 64'h0000_0000_0000_0003);
    // R2/R5: narrow field in the upper segment only.
    loadSlide(64'h8000_0000_0000_FFFF);
    step(3'b011, 1, 0, 0, 0, 0, 0, 0, 0); checkAll("R2");
    check("R5", "ram kept", slideMask, 64'hC000_0000_0000_FFFF);
    // R2/R5: field at the bottom, shift left stops at bit 15.
    loadSlide(64'hFFFF_0000_0000_8001);
    step(3'b111, 0, 1, 0, 0, 0, 0, 0, 0); checkAll("R2");
    check("R5", "low field", slideMask, 64'hFFFF_0000_0000_0003);
    // R6: conflicting request.
    step(3'b000, 1, 1, 0, 0, 0, 0, 0, 0); checkAll("R6");
    // R8: write beats shift.
    step(3'b000, 1, 0, 1, 2'b00, 2'd2, 16'hA5A5, 16'h00FF, 0); checkAll("R8");
    // R9: swap with a write to the active copy uses pre-swap roles.
    step(3'b000, 0, 0, 1, 2'b01, 2'd1, 16'h1234, 16'h0, 1); checkAll("R9");
    step(3'b000, 0, 0, 1, 2'b10, 2'd3, 16'hBEEF, 16'hF000, 0); checkAll("R7");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      bit sr = r[0] | r[1], sl = r[2] | r[3], we = (r[5:4] == 2'b00), sw = (r[9:6] == 4'h0);
      string tag;
      logic [15:0] k = r[10] ? 16'h0 : 16'($urandom);
      if (we) tag = (r[12:11] == 2'b00 && (sr || sl)) ? "R8" : "R7";
      else if (sr && sl) tag = "R6";
      else if (sr) tag = "R3";
      else if (sl) tag = "R4";
      else if (sw) tag = "R9";
      else tag = "R5";
      step(3'(r[15:13]), sr, sl, we, r[12:11], r[17:16], 16'($urandom), k, sw);
      checkAll(tag);
    end
    finishRun();
  end
endmodule